// File: doc/BRIEF.md
# Posted-Write Register Bridge

This block connects a register bus running on a fast interface clock to register logic running on a much slower functional clock. A write to one of the functional-side registers is held in a per-register staging register. Its arrival is signalled across the clock boundary by a toggle that passes through a two-flop synchronizer. The functional side raises an update strobe with the staged value for one functional cycle. It then returns the toggle through a second synchronizer as an acknowledge. Each such register has its own in-flight bit, and software can read all of these bits together in a status word.

By default the bridge runs in posted mode. Every access finishes in one interface cycle. Software must poll the in-flight bits, because a second write to a register that is still in flight is thrown away, and a read of that register returns an error response. When posted mode is cleared, the bridge stalls the bus instead: a write holds the ready signal low until its own acknowledge returns, so software never sees a bit in flight.

A soft reset is requested through the mode register. It travels over the same handshake path, pulses a reset strobe on the functional side, and reports completion in a done bit.

Top module: `posted_wr_bridge`

## Requirements
- R1: After reset, the mode register (address 3) reads 0x4 (bit 2 = posted mode on), the status register (address 1) reads 1 (bit 0 = soft reset done), and the in-flight word (address 2) reads 0.
- R2: In posted mode every access completes with ready high in its first cycle. A write to functional register i (address 16+i, i = 0..9) that is not in flight sets bit i of the in-flight word, starting with the cycle after the accepting edge.
- R3: After a write to register i is accepted, the functional side raises strobe bit i for exactly one functional cycle at the third functional clock edge after acceptance, and the data output for register i then carries the written value. In-flight bit i clears at the second interface edge after that functional edge.
- R4: In posted mode, a write to a register whose in-flight bit is set is discarded: no strobe, and the stored value is kept.
- R5: In posted mode, reading a register whose in-flight bit is set returns the error flag with data 0. Reading a register that is not in flight returns the last accepted value with the error flag low.
- R6: Writing the mode register with bit 2 = 0 selects stalling mode. In that mode a write to a functional register holds ready low until its acknowledge has returned, a read of a register in flight stalls the same way, and the in-flight word reads 0.
- R7: The in-flight word is read-only. Writes to address 2 change nothing.
- R8: A mode-register write with bit 1 set (for example 0x06) forces posted mode on. If no soft reset is running, it starts one: status bit 0 reads 0 from the next cycle until the handshake returns, with the same latency as R3. A single strobe appears on the soft-reset output. Functional-register writes made during the reset are discarded.
- R9: Address 0 reads the fixed identification value 0x50570001. The identification, status, in-flight and mode registers never report an error.
- R10: Addresses outside the map read 0 with ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| iclk | input | 1 | Interface clock |
| irst_n | input | 1 | Interface-domain reset, active low, asynchronous |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes in a cycle with request and ready both high |
| bus_rdata | output | 32 | Read data, valid when ready is high |
| bus_err | output | 1 | Error response for a read of a register still in flight |
| fclk | input | 1 | Functional clock |
| frst_n | input | 1 | Functional-domain reset, active low, asynchronous |
| fn_wr_stb | output | 10 | One-cycle update strobe per functional register |
| fn_wr_data | output | 320 | Latest delivered value per register, register i in bits 32*i+31..32*i |
| fn_soft_rst | output | 1 | One-cycle soft-reset strobe in the functional domain |

## Verification
The assertions rely on two assumptions about the bus master. It holds request, address, direction and data steady until ready is seen. It does not abandon a stalled write. The bench's access task keeps to both. It changes inputs only between edges and only drops a request after the edge that completed it. The bench also keeps the functional clock eight times slower than the interface clock, with edges offset so that no two edges coincide. Under these conditions the synchronizer round trip is exactly three functional edges plus two interface edges, and the bench can predict every in-flight bit, strobe and stall cycle by cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    // Word addresses of the bridge's own registers.
    localparam int unsigned ADDR_ID      = 0;
    localparam int unsigned ADDR_SYS     = 1;
    localparam int unsigned ADDR_INFLT   = 2;
    localparam int unsigned ADDR_MODE    = 3;
    // First word address of the functional (posted) registers.
    localparam int unsigned POSTED_BASE  = 16;
    // Mode register fields.
    localparam int unsigned MODE_POSTED_BIT = 2;
    localparam int unsigned MODE_SRST_BIT   = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_SYS,
        SEL_INFLT,
        SEL_MODE,
        SEL_FUNC
    } sel_e;
endpackage

// File: rtl/pwb_sync.sv
module pwb_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = d;
        for (int k = 1; k < STAGES; k++) begin
            sr_d[k] = sr_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pwb_bus_side.sv
module pwb_bus_side
    import pwb_pkg::*;
#(
    parameter int unsigned        DATA_W     = 32,
    parameter int unsigned        ADDR_W     = 6,
    parameter int unsigned        NUM_POSTED = 10,
    parameter logic [DATA_W-1:0]  ID_VALUE   = 32'h5057_0001
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         ready,
    output logic                         err,
    output logic [DATA_W-1:0]            rdata,
    input  logic [NUM_POSTED:0]          ack_s,
    output logic [NUM_POSTED:0]          req_tgl,
    output logic [NUM_POSTED*DATA_W-1:0] hold_flat
);
    localparam int unsigned IDX_W = (NUM_POSTED > 1) ? $clog2(NUM_POSTED) : 1;
    localparam int unsigned SRST  = NUM_POSTED;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(POSTED_BASE);
    localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(POSTED_BASE + NUM_POSTED);

    typedef struct packed {
        logic [NUM_POSTED-1:0][DATA_W-1:0] hold;
        logic [NUM_POSTED:0]               tgl;
        logic                              np_wait;
        logic                              posted;
    } bus_st_t;

    bus_st_t st_d, st_q;

    logic [NUM_POSTED:0]   flight;
    logic [NUM_POSTED-1:0] pend;
    logic [NUM_POSTED-1:0] sel_oh;
    logic                  done;
    logic                  sel_pend;
    logic [IDX_W-1:0]      idx;
    sel_e                  sel;
    logic                  launch;
    logic                  srst_start;

    // Address decode and in-flight state.
    always_comb begin
        flight   = st_q.tgl ^ ack_s;
        pend     = flight[NUM_POSTED-1:0];
        done     = ~flight[SRST];
        idx      = IDX_W'(addr - BASE_A);
        sel      = SEL_NONE;
        if ((addr >= BASE_A) && (addr < END_A)) begin
            sel = SEL_FUNC;
        end else if (addr == ADDR_W'(ADDR_ID)) begin
            sel = SEL_ID;
        end else if (addr == ADDR_W'(ADDR_SYS)) begin
            sel = SEL_SYS;
        end else if (addr == ADDR_W'(ADDR_INFLT)) begin
            sel = SEL_INFLT;
        end else if (addr == ADDR_W'(ADDR_MODE)) begin
            sel = SEL_MODE;
        end
        sel_oh   = (sel == SEL_FUNC) ? (NUM_POSTED'(1) << idx) : '0;
        sel_pend = |(pend & sel_oh);
    end

    // Next-state and bus response.
    always_comb begin
        st_d       = st_q;
        ready      = 1'b1;
        err        = 1'b0;
        rdata      = '0;
        launch     = 1'b0;
        srst_start = 1'b0;
        if (req) begin
            unique case (sel)
                SEL_FUNC: begin
                    if (we) begin
                        if (st_q.posted || !done) begin
                            launch = done && !sel_pend;
                        end else if (st_q.np_wait) begin
                            ready = !sel_pend;
                            if (!sel_pend) begin
                                st_d.np_wait = 1'b0;
                            end
                        end else begin
                            ready = 1'b0;
                            if (!sel_pend) begin
                                launch       = 1'b1;
                                st_d.np_wait = 1'b1;
                            end
                        end
                    end else if (st_q.posted) begin
                        err   = sel_pend;
                        rdata = sel_pend ? '0 : st_q.hold[idx];
                    end else begin
                        ready = !sel_pend;
                        rdata = st_q.hold[idx];
                    end
                end
                SEL_ID: begin
                    if (!we) rdata = ID_VALUE;
                end
                SEL_SYS: begin
                    if (!we) rdata = DATA_W'(done);
                end
                SEL_INFLT: begin
                    if (!we && st_q.posted) rdata = DATA_W'(pend);
                end
                SEL_MODE: begin
                    if (!we) begin
                        rdata = DATA_W'(st_q.posted) << MODE_POSTED_BIT;
                    end else if (wdata[MODE_SRST_BIT]) begin
                        st_d.posted = 1'b1;
                        srst_start  = done;
                    end else begin
                        st_d.posted = wdata[MODE_POSTED_BIT];
                    end
                end
                default: ;
            endcase
        end
        if (launch) begin
            st_d.hold[idx] = wdata;
            st_d.tgl[idx]  = ~st_q.tgl[idx];
        end
        if (srst_start) begin
            st_d.tgl[SRST] = ~st_q.tgl[SRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.posted <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_tgl   = st_q.tgl;
    assign hold_flat = st_q.hold;

    // R2: posted mode never stalls.
    p_posted_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.posted && req) |-> ready);
    // R2: an accepted write shows up as in flight on the next cycle.
    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> |(pend & $past(sel_oh)));
    // R4: a write hitting a register in flight leaves all staged values alone.
    p_drop_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (sel == SEL_FUNC) && st_q.posted && sel_pend) |=> $stable(st_q.hold));
    // R5: the error response belongs to posted-mode reads only.
    p_err_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (req && !we && st_q.posted));
    // R6: a stalling-mode write only completes once nothing is in flight for it.
    p_np_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.posted && done && req && we && (sel == SEL_FUNC) && ready) |-> !sel_pend);
    // R7: writes to the in-flight word change no state.
    p_inflt_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && (sel == SEL_INFLT)) |=> $stable(st_q));
    // R8: starting a soft reset drops the done bit on the next cycle.
    p_srst_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        srst_start |=> !done);
endmodule

// File: rtl/pwb_fn_side.sv
module pwb_fn_side #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_POSTED = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_POSTED:0]          req_s,
    input  logic [NUM_POSTED*DATA_W-1:0] hold_flat,
    output logic [NUM_POSTED:0]          ack_tgl,
    output logic [NUM_POSTED-1:0]        stb,
    output logic [NUM_POSTED*DATA_W-1:0] data_flat,
    output logic                         soft_rst
);
    typedef struct packed {
        logic [NUM_POSTED-1:0][DATA_W-1:0] data;
        logic [NUM_POSTED:0]               seen;
        logic [NUM_POSTED:0]               stb;
    } fn_st_t;

    fn_st_t st_d, st_q;
    logic [NUM_POSTED-1:0][DATA_W-1:0] hold_w;

    assign hold_w = hold_flat;

    always_comb begin
        st_d      = st_q;
        st_d.seen = req_s;
        st_d.stb  = req_s ^ st_q.seen;
        for (int i = 0; i < NUM_POSTED; i++) begin
            if (st_d.stb[i]) begin
                st_d.data[i] = hold_w[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_tgl   = st_q.seen;
    assign stb       = st_q.stb[NUM_POSTED-1:0];
    assign soft_rst  = st_q.stb[NUM_POSTED];
    assign data_flat = st_q.data;

    // R3: each update strobe lasts a single functional cycle.
    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.stb) |=> ((st_q.stb & $past(st_q.stb)) == '0));
endmodule

// File: rtl/posted_wr_bridge.sv
module posted_wr_bridge #(
    parameter int unsigned       DATA_W      = 32,
    parameter int unsigned       ADDR_W      = 6,
    parameter int unsigned       NUM_POSTED  = 10,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] ID_VALUE    = 32'h5057_0001
) (
    input  logic                         iclk,
    input  logic                         irst_n,
    input  logic                         bus_req,
    input  logic                         bus_we,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic                         bus_ready,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         bus_err,
    input  logic                         fclk,
    input  logic                         frst_n,
    output logic [NUM_POSTED-1:0]        fn_wr_stb,
    output logic [NUM_POSTED*DATA_W-1:0] fn_wr_data,
    output logic                         fn_soft_rst
);
    localparam int unsigned CH = NUM_POSTED + 1;

    logic [CH-1:0]                req_tgl, req_s, ack_tgl, ack_s;
    logic [NUM_POSTED*DATA_W-1:0] hold_flat;

    pwb_bus_side #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_POSTED(NUM_POSTED), .ID_VALUE(ID_VALUE)
    ) u_bus (
        .clk(iclk), .rst_n(irst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .ready(bus_ready), .err(bus_err), .rdata(bus_rdata),
        .ack_s(ack_s), .req_tgl(req_tgl), .hold_flat(hold_flat)
    );

    pwb_sync #(.WIDTH(CH), .STAGES(SYNC_STAGES)) u_sync_req (
        .clk(fclk), .rst_n(frst_n), .d(req_tgl), .q(req_s)
    );

    pwb_fn_side #(.DATA_W(DATA_W), .NUM_POSTED(NUM_POSTED)) u_fn (
        .clk(fclk), .rst_n(frst_n), .req_s(req_s), .hold_flat(hold_flat),
        .ack_tgl(ack_tgl), .stb(fn_wr_stb), .data_flat(fn_wr_data), .soft_rst(fn_soft_rst)
    );

    pwb_sync #(.WIDTH(CH), .STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(iclk), .rst_n(irst_n), .d(ack_tgl), .q(ack_s)
    );
endmodule

// File: tb/tb_posted_wr_bridge.sv
module tb_posted_wr_bridge;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int N  = 10;
    localparam int BASE = 16;
    localparam logic [DW-1:0] ID = 32'h5057_0001;

    logic iclk = 0, fclk = 0, irst_n = 0, frst_n = 0;
    logic bus_req = 0, bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic bus_ready, bus_err, fn_soft_rst;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0] fn_wr_stb;
    logic [N*DW-1:0] fn_wr_data;

    // 250 MHz interface clock; functional clock 8x slower, edges offset.
    always #2 iclk = ~iclk;
    initial begin
        #5;
        forever begin
            fclk = ~fclk;
            #16;
        end
    end

    posted_wr_bridge dut (
        .iclk(iclk), .irst_n(irst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .fclk(fclk), .frst_n(frst_n),
        .fn_wr_stb(fn_wr_stb), .fn_wr_data(fn_wr_data), .fn_soft_rst(fn_soft_rst)
    );

    int checks = 0, fails = 0, cyc = 0;
    string phase = "R1";

    // Reference model. Slot N is the soft-reset channel.
    bit m_posted, m_npwait;
    bit [N:0] m_pend;
    logic [DW-1:0] m_hold [N];
    int launch_c [N+1], iseen [N+1], icnt [N+1];
    int ftaken [N+1], fcnt [N+1], fdone [N+1];
    bit e_stb [N+1];
    logic [DW-1:0] e_data [N];
    int stb_cnt [N+1];

    task automatic predict(output bit rdy, output bit er, output logic [DW-1:0] rd,
                           output int lidx, output int newp, output bit np_set, output bit np_clr);
        bit dn, p;
        int a, i;
        rdy = 1; er = 0; rd = '0; lidx = -1; newp = -1; np_set = 0; np_clr = 0;
        dn = !m_pend[N];
        a = int'(bus_addr);
        if (bus_req) begin
            if (a >= BASE && a < BASE + N) begin
                i = a - BASE;
                p = m_pend[i];
                if (bus_we) begin
                    if (m_posted || !dn) begin
                        if (dn && !p) lidx = i;
                    end else if (m_npwait) begin
                        rdy = !p;
                        np_clr = !p;
                    end else begin
                        rdy = 0;
                        if (!p) begin lidx = i; np_set = 1; end
                    end
                end else if (m_posted) begin
                    er = p;
                    rd = p ? '0 : m_hold[i];
                end else begin
                    rdy = !p;
                    rd = m_hold[i];
                end
            end else if (!bus_we) begin
                case (a)
                    0: rd = ID;
                    1: rd = DW'(dn);
                    2: rd = m_posted ? DW'(m_pend[N-1:0]) : '0;
                    3: rd = DW'(m_posted) << 2;
                    default: rd = '0;
                endcase
            end else if (a == 3) begin
                if (bus_wdata[1]) begin
                    newp = 1;
                    if (dn) lidx = N;
                end else begin
                    newp = int'(bus_wdata[2]);
                end
            end
        end
    endtask

    always @(posedge iclk) begin
        bit rdy, er, ns, nc;
        logic [DW-1:0] rd;
        int li, np;
        if (!irst_n) begin
            m_posted = 1; m_npwait = 0; m_pend = '0;
            for (int i = 0; i <= N; i++) begin
                launch_c[i] = 0; iseen[i] = 0; icnt[i] = 0;
                if (i < N) m_hold[i] = '0;
            end
        end else begin
            predict(rdy, er, rd, li, np, ns, nc);
            for (int i = 0; i <= N; i++) begin
                if (icnt[i] > 0) begin
                    icnt[i]--;
                    if (icnt[i] == 0) m_pend[i] = 0;
                end else if (fdone[i] != iseen[i]) begin
                    iseen[i]++;
                    icnt[i] = 1;
                end
            end
            if (np >= 0) m_posted = (np != 0);
            if (ns) m_npwait = 1;
            if (nc) m_npwait = 0;
            if (li >= 0) begin
                if (li < N) m_hold[li] = bus_wdata;
                m_pend[li] = 1;
                launch_c[li]++;
            end
        end
    end

    always @(posedge fclk) begin
        if (!frst_n) begin
            for (int i = 0; i <= N; i++) begin
                ftaken[i] = 0; fcnt[i] = 0; fdone[i] = 0; e_stb[i] = 0;
                if (i < N) e_data[i] = '0;
            end
        end else begin
            for (int i = 0; i <= N; i++) begin
                e_stb[i] = 0;
                if (fcnt[i] > 0) begin
                    fcnt[i]--;
                    if (fcnt[i] == 0) begin
                        e_stb[i] = 1;
                        fdone[i]++;
                        if (i < N) e_data[i] = m_hold[i];
                    end
                end else if (launch_c[i] != ftaken[i]) begin
                    ftaken[i]++;
                    fcnt[i] = 2;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bus response compared on every interface clock.
    always @(negedge iclk) begin
        bit rdy, er, ns, nc;
        logic [DW-1:0] rd;
        int li, np;
        if (irst_n) begin
            predict(rdy, er, rd, li, np, ns, nc);
            chk({phase, " ready"}, DW'(bus_ready), DW'(rdy));
            chk({phase, " err"}, DW'(bus_err), DW'(er));
            chk({phase, " rdata"}, bus_rdata, rd);
        end
    end

    // Functional side compared on every functional clock (R3 strobe timing).
    always @(negedge fclk) begin
        if (frst_n) begin
            for (int i = 0; i < N; i++) begin
                chk({phase, " R3 strobe"}, DW'(fn_wr_stb[i]), DW'(e_stb[i]));
                chk({phase, " R3 data"}, fn_wr_data[i*DW +: DW], e_data[i]);
                if (fn_wr_stb[i]) stb_cnt[i]++;
            end
            chk({phase, " R8 soft reset strobe"}, DW'(fn_soft_rst), DW'(e_stb[N]));
            if (fn_soft_rst) stb_cnt[N]++;
        end
    end

    always @(posedge iclk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL %s: watchdog at cycle %0d expected below %0d", phase, cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic access(input bit we, input int addr, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output bit er, output int waits);
        bus_req = 1; bus_we = we; bus_addr = AW'(addr); bus_wdata = d;
        waits = 0;
        forever begin
            @(negedge iclk);
            if (bus_ready) break;
            waits++;
        end
        rd = bus_rdata; er = bus_err;
        @(posedge iclk);
        #1;
        bus_req = 0; bus_we = 0;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] d);
        logic [DW-1:0] rd; bit er; int w;
        access(1, addr, d, rd, er, w);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge iclk);
        #1;
    endtask

    initial begin
        logic [DW-1:0] rd;
        bit er;
        int w;
        for (int i = 0; i <= N; i++) stb_cnt[i] = 0;
        repeat (4) @(posedge iclk);
        #1;
        irst_n = 1; frst_n = 1;
        idle(3);

        phase = "R1";
        access(0, 3, 0, rd, er, w); chk("R1 mode reset", rd, 32'h4);
        access(0, 1, 0, rd, er, w); chk("R1 done reset", rd, 32'h1);
        access(0, 2, 0, rd, er, w); chk("R1 in-flight reset", rd, 32'h0);
        phase = "R9";
        access(0, 0, 0, rd, er, w); chk("R9 id", rd, ID);
        phase = "R10";
        access(0, 63, 0, rd, er, w); chk("R10 unmapped", rd, 32'h0);

        phase = "R2";
        wr(BASE + 0, 32'hA0A0_0000);
        wr(BASE + 5, 32'hA5A5_0005);
        wr(BASE + 9, 32'hA9A9_0009);
        access(0, 2, 0, rd, er, w); chk("R2 in-flight bits", rd, 32'h221);
        phase = "R3";
        for (int k = 0; k < 40; k++) access(0, 2, 0, rd, er, w);
        chk("R3 in-flight cleared", rd, 32'h0);
        chk("R3 one strobe reg0", DW'(stb_cnt[0]), 32'd1);

        phase = "R4";
        wr(BASE + 3, 32'h0000_1111);
        wr(BASE + 3, 32'h0000_2222);
        idle(40);
        access(0, BASE + 3, 0, rd, er, w); chk("R4 kept value", rd, 32'h1111);
        chk("R4 single strobe reg3", DW'(stb_cnt[3]), 32'd1);

        phase = "R5";
        wr(BASE + 1, 32'h55);
        access(0, BASE + 1, 0, rd, er, w); chk("R5 error on in-flight read", DW'(er), 32'd1);
        idle(40);
        access(0, BASE + 1, 0, rd, er, w);
        chk("R5 read value", rd, 32'h55);
        chk("R5 no error", DW'(er), 32'd0);

        phase = "R7";
        wr(2, 32'h3FF);
        wr(BASE + 2, 32'h22);
        wr(2, 32'h0);
        access(0, 2, 0, rd, er, w); chk("R7 in-flight unaffected", rd, 32'h4);
        idle(40);

        phase = "R6";
        wr(3, 32'h0);
        access(0, 3, 0, rd, er, w); chk("R6 mode off", rd, 32'h0);
        access(1, BASE + 4, 32'h44, rd, er, w); chk("R6 write stalled", DW'(w > 20), 32'd1);
        wr(3, 32'h4);
        wr(BASE + 6, 32'h66);
        wr(3, 32'h0);
        access(0, 2, 0, rd, er, w); chk("R6 in-flight reads zero", rd, 32'h0);
        access(0, BASE + 6, 0, rd, er, w);
        chk("R6 stalled read value", rd, 32'h66);
        chk("R6 read stalled", DW'(w > 0), 32'd1);

        phase = "R8";
        wr(3, 32'h6);
        access(0, 1, 0, rd, er, w); chk("R8 done low", rd, 32'h0);
        access(0, 3, 0, rd, er, w); chk("R8 posted forced", rd, 32'h4);
        wr(BASE + 7, 32'h77);
        idle(40);
        access(0, 1, 0, rd, er, w); chk("R8 done high", rd, 32'h1);
        access(0, BASE + 7, 0, rd, er, w); chk("R8 write during reset dropped", rd, 32'h0);
        chk("R8 one soft reset strobe", DW'(stb_cnt[N]), 32'd1);

        phase = "R2";
        for (int i = 0; i < N; i++) wr(BASE + i, DW'(32'h0101 * (i + 1)));
        idle(40);
        phase = "R3";
        for (int i = 0; i < N; i++) begin
            access(0, BASE + i, 0, rd, er, w);
            chk("R3 burst readback", rd, DW'(32'h0101 * (i + 1)));
        end
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule